// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 262,144 four-bit words. A client presents one request at a time: a valid flag, a write flag, an 18-bit word address and, for a write, a 4-bit value. The controller accepts the request while it signals ready. It then drives the memory strobes through a fixed sequence. When a read finishes, it returns the fetched nibble with a one-cycle valid pulse.

The memory has no clock, so every strobe phase is stretched over whole clock cycles. The cycle counts are worked out when the block is elaborated: each is the ceiling of a nanosecond minimum divided by the clock period.

- A read holds the memory in its read mode for the address-access time.
- A write keeps the output-enable strobe high. It first waits out the memory's output-release time with write enable already low. Only then does it drive the data bus, and it keeps driving it for the data-setup time. Write enable stays low for at least the write-pulse minimum.

The shared data bus appears as separate out, in and drive-enable signals. The strobes follow the memory's mode table:

| Chip enable | Write enable | Output enable | Memory mode |
|---|---|---|---|
| high | any | any | standby |
| low | low | any | write |
| low | high | low | read |
| low | high | high | outputs off |

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after it, req_ready is 1 and rsp_valid is 0. The three strobes sram_ce_n, sram_we_n and sram_oe_n are all 1, and sram_dq_oe is 0.
- R2: In every cycle where the controller is idle and ready, the memory is in standby (sram_ce_n = 1) and the controller does not drive the bus (sram_dq_oe = 0).
- R3: A read holds sram_ce_n = 0, sram_oe_n = 0 and sram_we_n = 1 for RD_CYC = ceil(T_AA_PS / CLK_PS) cycles. It samples sram_dq_in at the clock edge that ends the last of these cycles. The returned value equals the nibble most recently written to that address.
- R4: Each read produces exactly one rsp_valid pulse, one cycle long. The pulse comes in the first cycle that req_ready is 1 again. A write produces no pulse.
- R5: During a write, sram_ce_n = 0 and sram_we_n = 0 while sram_oe_n stays 1 for the whole write.
- R6: sram_we_n stays 0 for at least ceil(T_WP_PS / CLK_PS) cycles. sram_dq_oe is 1 for at least ceil(T_DS_PS / CLK_PS) cycles before sram_we_n rises. The data stays constant over that time.
- R7: The controller never drives the bus while the memory may drive it. sram_dq_oe is 0 whenever sram_oe_n is 0. It is also 0 for the first TURN_CYC = ceil(T_OFF_PS / CLK_PS) cycles after sram_we_n falls.
- R8: A request is accepted only when req_valid and req_ready are both 1 at a clock edge. req_ready is then 0 from the next cycle until the access is complete.
- R9: sram_addr stays constant while sram_ce_n is 0.
- R10: The controller returns to ready RD_CYC + 1 cycles after it accepts a read. It returns to ready TURN_CYC + DATA_CYC + 2 cycles after it accepts a write. Here DATA_CYC = max(ceil(T_DS_PS / CLK_PS), ceil(T_WP_PS / CLK_PS) - TURN_CYC, 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write value |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle pulse: read data is valid |
| rsp_rdata | output | 4 | Read data |
| sram_addr | output | 18 | Memory address bus |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_dq_out | output | 4 | Value the controller drives onto the data bus |
| sram_dq_oe | output | 1 | Controller drives the data bus |
| sram_dq_in | input | 4 | Value present on the data bus |

## Verification
The hardest case to reach is the bus hand-over. A write accepted in the very cycle that a read's data pulse appears must not drive the bus while the memory is still releasing it. The bench reaches this case with read-then-write pairs that leave no gap between them. Its memory model keeps driving the bus for its release window after a read ends, so a missing or short turn-around shows up as a clash. The same model returns corrupted data until the access time has passed, and it measures the write-pulse and setup windows itself. This makes early sampling and short strobes visible at the ports.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_READ    = 2'd1,
        MODE_WRITE   = 2'd2,
        MODE_OUTOFF  = 2'd3
    } mem_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RACC  = 3'd1,
        ST_WTURN = 3'd2,
        ST_WDRV  = 3'd3,
        ST_WEND  = 3'd4
    } ctl_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_strobe_map.sv
module sram_strobe_map
    import sram_ctl_pkg::*;
(
    input  mem_mode_e mode,
    output logic      ce_n,
    output logic      we_n,
    output logic      oe_n
);

    always_comb begin
        ce_n = 1'b1;
        we_n = 1'b1;
        oe_n = 1'b1;
        case (mode)
            MODE_READ:   begin ce_n = 1'b0; oe_n = 1'b0; end
            MODE_WRITE:  begin ce_n = 1'b0; we_n = 1'b0; end
            MODE_OUTOFF: begin ce_n = 1'b0; end
            default:     begin end
        endcase
    end

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R10
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 4,
    parameter int CLK_PS    = 4000,
    parameter int T_AA_PS   = 10000,
    parameter int T_WP_PS   = 9000,
    parameter int T_DS_PS   = 7000,
    parameter int T_OFF_PS  = 7000,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int RD_CYC    = max_int(ceil_div(T_AA_PS, CLK_PS), 1);
    localparam int PULSE_CYC = max_int(ceil_div(T_WP_PS, CLK_PS), 1);
    localparam int SETUP_CYC = max_int(ceil_div(T_DS_PS, CLK_PS), 1);
    localparam int TURN_CYC  = max_int(ceil_div(T_OFF_PS, CLK_PS), 1);
    localparam int DATA_CYC  = max_int(max_int(SETUP_CYC, PULSE_CYC - TURN_CYC), 1);

    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] DATA_LOAD = CNT_W'(DATA_CYC - 1);

    typedef struct packed {
        ctl_state_e        st;
        mem_mode_e         mode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              dq_oe;
    } ctl_regs_t;

    ctl_regs_t         r_d, r_q;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_zero;

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        t_load     = 1'b0;
        t_val      = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    t_load    = 1'b1;
                    if (req_write) begin
                        r_d.st   = ST_WTURN;
                        r_d.mode = MODE_WRITE;
                        t_val    = TURN_LOAD;
                    end else begin
                        r_d.st   = ST_RACC;
                        r_d.mode = MODE_READ;
                        t_val    = RD_LOAD;
                    end
                end
            end
            ST_RACC: begin
                if (t_zero) begin
                    r_d.rdata  = sram_dq_in;
                    r_d.rvalid = 1'b1;
                    r_d.st     = ST_IDLE;
                    r_d.mode   = MODE_STANDBY;
                end
            end
            ST_WTURN: begin
                if (t_zero) begin
                    r_d.st    = ST_WDRV;
                    r_d.dq_oe = 1'b1;
                    t_load    = 1'b1;
                    t_val     = DATA_LOAD;
                end
            end
            ST_WDRV: begin
                if (t_zero) begin
                    r_d.st   = ST_WEND;
                    r_d.mode = MODE_STANDBY;
                end
            end
            ST_WEND: begin
                r_d.st    = ST_IDLE;
                r_d.dq_oe = 1'b0;
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.mode  = MODE_STANDBY;
                r_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.mode   <= MODE_STANDBY;
            r_q.addr   <= '0;
            r_q.wdata  <= '0;
            r_q.rdata  <= '0;
            r_q.rvalid <= 1'b0;
            r_q.dq_oe  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    sram_strobe_map strobe_i (
        .mode (r_q.mode),
        .ce_n (sram_ce_n),
        .we_n (sram_we_n),
        .oe_n (sram_oe_n)
    );

    assign req_ready   = (r_q.st == ST_IDLE);
    assign rsp_valid   = r_q.rvalid;
    assign rsp_rdata   = r_q.rdata;
    assign sram_addr   = r_q.addr;
    assign sram_dq_out = r_q.wdata;
    assign sram_dq_oe  = r_q.dq_oe;

    // Window counters for the timing checks below
    logic [7:0] we_low_cnt_q, drv_cnt_q, turn_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt_q <= '0;
            drv_cnt_q    <= '0;
            turn_cnt_q   <= '0;
        end else begin
            we_low_cnt_q <= !sram_we_n ? ((we_low_cnt_q == 8'hFF) ? we_low_cnt_q : we_low_cnt_q + 1'b1) : '0;
            drv_cnt_q    <= (!sram_we_n && sram_dq_oe) ? ((drv_cnt_q == 8'hFF) ? drv_cnt_q : drv_cnt_q + 1'b1) : '0;
            turn_cnt_q   <= (!sram_we_n && !sram_dq_oe) ? ((turn_cnt_q == 8'hFF) ? turn_cnt_q : turn_cnt_q + 1'b1) : '0;
        end
    end

    // R5
    write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n));

    // R6
    write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (32'(we_low_cnt_q) >= PULSE_CYC && 32'(drv_cnt_q) >= SETUP_CYC));

    // R6
    write_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

    // R7
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    // R7
    turn_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (32'(turn_cnt_q) >= TURN_CYC));

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R4
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // R2
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && !sram_dq_oe));

endmodule

// File: tb/sram_async_ctl_tb_top.sv
module sram_async_ctl_tb_top;

    localparam int CLK_PS  = 4000;
    localparam int TAA_PS  = 10000;
    localparam int TWP_PS  = 9000;
    localparam int TDS_PS  = 7000;
    localparam int TOFF_PS = 7000;

    localparam int E_RD   = (TAA_PS + CLK_PS - 1) / CLK_PS;
    localparam int E_WP   = (TWP_PS + CLK_PS - 1) / CLK_PS;
    localparam int E_DS   = (TDS_PS + CLK_PS - 1) / CLK_PS;
    localparam int E_TURN = (TOFF_PS + CLK_PS - 1) / CLK_PS;
    localparam int E_DATA = (E_DS > E_WP - E_TURN) ? E_DS : E_WP - E_TURN;
    // negedges that fall inside the memory's release window (first one 2 ns after the edge)
    localparam int REL_NE = (TOFF_PS - CLK_PS / 2 + CLK_PS - 1) / CLK_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [3:0]  rsp_rdata;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [3:0]  sram_dq_out, sram_dq_in;

    always #2ns clk = ~clk;

    sram_async_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    // ---------------- memory model ----------------
    logic [3:0] mem [0:1023];
    int  rd_cnt = 0, rel_cnt = 0, wp_cnt = 0, ds_cnt = 0;
    int  m_writes = 0, m_wp_bad = 0, m_ds_bad = 0, m_addr_bad = 0, m_clash = 0;
    logic prev_wcond = 1'b0;
    logic [17:0] w_addr = '0;
    logic [3:0]  w_data = '0;

    wire rcond = !sram_ce_n && sram_we_n && !sram_oe_n;
    wire wcond = !sram_ce_n && !sram_we_n;

    assign sram_dq_in = (rcond && rd_cnt * CLK_PS >= TAA_PS) ? mem[sram_addr[9:0]]
                                                             : ~mem[sram_addr[9:0]];

    initial for (int i = 0; i < 1024; i++) mem[i] = 4'h0;

    always @(negedge clk) begin
        if (rst_n) begin
            // read access and release window
            if (rcond) begin
                rd_cnt  <= rd_cnt + 1;
                rel_cnt <= REL_NE;
                if (sram_dq_oe) m_clash <= m_clash + 1;
            end else begin
                rd_cnt <= 0;
                if (rel_cnt > 0) begin
                    if (sram_dq_oe) m_clash <= m_clash + 1;
                    rel_cnt <= rel_cnt - 1;
                end
            end
            // write windows
            if (wcond) begin
                if (!prev_wcond) w_addr <= sram_addr;
                else if (sram_addr != w_addr) m_addr_bad <= m_addr_bad + 1;
                wp_cnt <= wp_cnt + 1;
                if (sram_dq_oe) begin
                    if (ds_cnt > 0 && sram_dq_out != w_data) ds_cnt <= 1;
                    else ds_cnt <= ds_cnt + 1;
                    w_data <= sram_dq_out;
                end else ds_cnt <= 0;
            end else if (prev_wcond) begin
                if (wp_cnt * CLK_PS < TWP_PS) m_wp_bad <= m_wp_bad + 1;
                if (ds_cnt * CLK_PS < TDS_PS || !sram_dq_oe || sram_dq_out != w_data)
                    m_ds_bad <= m_ds_bad + 1;
                mem[w_addr[9:0]] <= w_data;
                m_writes <= m_writes + 1;
                wp_cnt <= 0;
                ds_cnt <= 0;
            end
            prev_wcond <= wcond;
        end
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic [3:0] shadow [0:1023];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input bit wr, input logic [17:0] a, input logic [3:0] d);
        int lat, rv, wr_before, sbad;
        logic [3:0] got;
        while (!req_ready) @(negedge clk);
        wr_before = m_writes;
        sbad = m_wp_bad + m_ds_bad + m_addr_bad + m_clash;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 ready low after accept", int'(req_ready), 0);
        lat = 1; rv = 0; got = '0;
        while (!req_ready && lat < 60) begin
            if (rsp_valid) rv++;
            @(negedge clk);
            lat++;
        end
        if (rsp_valid) begin rv++; got = rsp_rdata; end
        chk(sram_ce_n && !sram_dq_oe, "R2 standby when ready", int'({sram_ce_n, sram_dq_oe}), 2);
        if (wr) begin
            shadow[a[9:0]] = d;
            chk(lat == E_TURN + E_DATA + 2, "R10 write latency", lat, E_TURN + E_DATA + 2);
            chk(rv == 0, "R4 no pulse on write", rv, 0);
            chk(m_writes == wr_before + 1, "R5 write strobe seen", m_writes - wr_before, 1);
            chk(m_wp_bad + m_ds_bad + m_addr_bad + m_clash == sbad,
                "R6/R7/R9 write timing violations", m_wp_bad + m_ds_bad + m_addr_bad + m_clash, sbad);
        end else begin
            chk(lat == E_RD + 1, "R10 read latency", lat, E_RD + 1);
            chk(rv == 1, "R4 one pulse per read", rv, 1);
            chk(got == shadow[a[9:0]], "R3 read data", int'(got), int'(shadow[a[9:0]]));
            chk(m_writes == wr_before && m_clash == 0, "R7 no clash after read", m_clash, 0);
        end
        @(negedge clk);
        chk(!rsp_valid, "R4 pulse one cycle", int'(rsp_valid), 0);
    endtask

    function automatic logic [17:0] addr_of(input int i);
        return {8'((i * 37) & 8'hFF), 10'(i)};
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) shadow[i] = 4'h0;
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe,
            "R1 reset state", int'({req_ready, rsp_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}), 6'b101110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe,
            "R1 after reset", int'({req_ready, rsp_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}), 6'b101110);
        // sweep: write every nibble value over 64 addresses
        for (int i = 0; i < 64; i++) run_op(1'b1, addr_of(i), 4'(i ^ (i >> 4)));
        // read back all
        for (int i = 0; i < 64; i++) run_op(1'b0, addr_of(i), 4'h0);
        // back-to-back read then write, then read of the new value (bus hand-over)
        for (int i = 0; i < 64; i++) begin
            run_op(1'b0, addr_of(i), 4'h0);
            run_op(1'b1, addr_of(i), 4'(~i));
            run_op(1'b0, addr_of(i), 4'h0);
        end
        // upper address bits vary with the same low bits: last write wins
        run_op(1'b1, {8'hA5, 10'd5}, 4'h9);
        run_op(1'b0, {8'hA5, 10'd5}, 4'h0);
        chk(m_clash == 0, "R7 total bus clashes", m_clash, 0);
        chk(m_wp_bad == 0, "R6 write pulse width", m_wp_bad, 0);
        chk(m_ds_bad == 0, "R6 data setup", m_ds_bad, 0);
        chk(m_addr_bad == 0, "R9 address stable", m_addr_bad, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule